// File: doc/BRIEF.md
# SPI Calendar-Clock Register File Slave

This block is the slave side of a serial peripheral link that looks, to a controller, like the register space of a calendar clock chip. Behind the link sit seven time-of-day and date registers, two banks of four alarm registers, a control register, a read-only status register, a trickle-charge configuration register and a small scratch RAM. It is meant as a behavioural counterpart for a controller under test. The controller reads and writes this space over SCK, MOSI, MISO and an active-high chip enable. The clock does not advance, alarms never match and no interrupt is produced; only the storage and its access rules are modelled.

Every transaction opens with a command byte. Its top bit chooses write or read and its lower seven bits give a starting address. Each further byte in the same chip-enable window moves to the next address. A write-protect flag in the control register discards writes everywhere except the control register. A second, parallel port lets the surrounding test logic look at any address without touching the serial link.

All serial inputs are brought into the system clock domain through a two-stage synchroniser. Edges of SCK are detected there, so SCK has to be much slower than the system clock.

Top module: `spi_rtc_regfile`

## Requirements
- R1: After reset the control register (address 0x0F) reads 0x40, which means write protect (bit 6) is set. Every other address reads 0x00.
- R2: Bits are shifted MSB first, and MOSI is taken on each SCK rising edge. In the first byte after chip enable rises, bit 7 = 1 selects a write and bit 7 = 0 a read, and bits 6:0 give the start address.
- R3: Each later byte in the same chip-enable window uses the next address, for both reads and writes. The address wraps from 0x7F to 0x00.
- R4: While control bit 6 is 1, a write to any address other than 0x0F leaves all storage unchanged. If protection is raised in the middle of a burst, it takes effect from the next byte on.
- R5: The control register keeps only bits 6, 2, 1 and 0; the other bits read 0. While bit 6 is 0, a control write loads all four kept bits. While bit 6 is 1, a control write changes only bit 6. Writing 0x00 twice therefore clears a protected register completely.
- R6: The status register at 0x10 always reads 0x00, and writes to it are ignored.
- R7: Addresses 0x12 to 0x1F, and every address from 0x20 + RAM_DEPTH upward, read 0x00 and ignore writes.
- R8: After the SCK falling edge that follows the last rising edge of a byte, MISO carries bit 7 of the byte being read; each later falling edge moves MISO to the next lower bit. MISO is 0 while chip enable is low, during the command byte and throughout a write.
- R9: When chip enable falls, the transaction ends and any partly received byte is discarded. The next rise of chip enable expects a new command byte.
- R10: dbg_data shows, combinationally, the contents of the address on dbg_addr. This is the same value a serial read of that address returns.
- R11: Time registers 0x00 to 0x06, alarm registers 0x07 to 0x0E, the trickle register 0x11 and RAM from 0x20 to 0x20 + RAM_DEPTH - 1 store all 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_ce | input | 1 | Active-high chip enable framing a transaction |
| spi_miso | output | 1 | Serial read data to the controller |
| dbg_addr | input | 7 | Address for the parallel look-up port |
| dbg_data | output | 8 | Contents at dbg_addr |

## Verification
A write is committed about three system clock cycles after the SCK rising edge that carries the last bit of its byte, because the edge passes through two synchroniser stages and one edge-detect stage before the register loads. A new MISO bit appears about three cycles after an SCK falling edge for the same reason. The bench holds each SCK level for eight system cycles. It samples MISO at the end of the low half, just before raising SCK, and reads the parallel port only after the chip enable has been low for several half periods. Every sample therefore falls well after its result is due.

// File: rtl/spi_rtc_regfile_pkg.sv
package spi_rtc_regfile_pkg;

    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 8;
    localparam int NUM_CORE    = 15;          // time 0x00-0x06, alarms 0x07-0x0E
    localparam int RAM_BASE    = 32;          // scratch RAM starts at 0x20
    localparam int WP_BIT      = 6;

    localparam logic [ADDR_W-1:0] A_CTRL    = 7'h0F;
    localparam logic [ADDR_W-1:0] A_STATUS  = 7'h10;
    localparam logic [ADDR_W-1:0] A_TRICKLE = 7'h11;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 8'h47;
    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h40;

    typedef enum logic {PH_CMD, PH_DATA} phase_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] b);
        cmd_t c;
        c.wr   = b[DATA_W-1];
        c.addr = b[ADDR_W-1:0];
        return c;
    endfunction

    // Next control value: only the protect flag may move while protection is on.
    function automatic logic [DATA_W-1:0] ctrl_next(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] wdat);
        logic [DATA_W-1:0] n;
        if (cur[WP_BIT]) begin
            n         = cur;
            n[WP_BIT] = wdat[WP_BIT];
        end else begin
            n = wdat & CTRL_KEEP;
        end
        return n;
    endfunction

endpackage

// File: rtl/spi_rtc_sync.sv
module spi_rtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic ce_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic ce_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sck_p, mosi_p, ce_p;
    logic         sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            mosi_p <= '0;
            ce_p   <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_p  <= {sck_p[TOP-1:0], sck_i};
            mosi_p <= {mosi_p[TOP-1:0], mosi_i};
            ce_p   <= {ce_p[TOP-1:0], ce_i};
            sck_d  <= sck_p[TOP];
        end
    end

    assign sck_rise = sck_p[TOP] & ~sck_d;
    assign sck_fall = ~sck_p[TOP] & sck_d;
    assign mosi_s   = mosi_p[TOP];
    assign ce_s     = ce_p[TOP];

endmodule

// File: rtl/spi_rtc_shifter.sv
module spi_rtc_shifter
    import spi_rtc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso_q
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;

    assign byte_done = sck_rise && (bit_cnt == CNT_W'(DATA_W - 1));
    assign rx_byte   = {rx_q[DATA_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst || !ce_s) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            miso_q  <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_q    <= rx_byte;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (load_en) begin
                tx_q <= load_data;
            end else if (sck_fall) begin
                miso_q <= tx_q[DATA_W-1];
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // R9: a partly shifted byte never survives a dropped chip enable
    a_r9_count_cleared: assert property (@(posedge clk) disable iff (rst)
        !ce_s |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_rtc_regbank.sv
module spi_rtc_regbank
    import spi_rtc_regfile_pkg::*;
#(
    parameter int RAM_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int CIW     = $clog2(NUM_CORE);
    localparam int RIW     = $clog2(RAM_DEPTH);
    localparam int RAM_END = RAM_BASE + RAM_DEPTH;
    localparam int NPORT   = 2;

    logic [NUM_CORE-1:0][DATA_W-1:0]  core_q;
    logic [RAM_DEPTH-1:0][DATA_W-1:0] ram_q;
    logic [DATA_W-1:0]                ctrl_q;
    logic [DATA_W-1:0]                trickle_q;

    logic              wr_in_ram;
    logic [ADDR_W-1:0] wr_off;
    logic [RIW-1:0]    wr_idx;

    assign wr_in_ram = (32'(wr_addr) >= RAM_BASE) && (32'(wr_addr) < RAM_END);
    assign wr_off    = wr_addr - ADDR_W'(RAM_BASE);
    assign wr_idx    = wr_off[RIW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q    <= '0;
            ram_q     <= '0;
            trickle_q <= '0;
            ctrl_q    <= CTRL_RESET;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                ctrl_q <= ctrl_next(ctrl_q, wr_data);
            end else if (!ctrl_q[WP_BIT]) begin
                if (32'(wr_addr) < NUM_CORE)
                    core_q[wr_addr[CIW-1:0]] <= wr_data;
                else if (wr_addr == A_TRICKLE)
                    trickle_q <= wr_data;
                else if (wr_in_ram)
                    ram_q[wr_idx] <= wr_data;
            end
        end
    end

    // Two identical read ports: one for the serial path, one for debug.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] off;
        logic [DATA_W-1:0] d;
        assign a   = (p == 0) ? rd_addr : dbg_addr;
        assign off = a - ADDR_W'(RAM_BASE);
        always_comb begin
            d = '0;
            if (32'(a) < NUM_CORE)
                d = core_q[a[CIW-1:0]];
            else if (a == A_CTRL)
                d = ctrl_q;
            else if (a == A_TRICKLE)
                d = trickle_q;
            else if ((32'(a) >= RAM_BASE) && (32'(a) < RAM_END))
                d = ram_q[off[RIW-1:0]];
        end
    end

    assign rd_data  = g_port[0].d;
    assign dbg_data = g_port[1].d;

    // R4: a protected write leaves every data register as it was
    a_r4_wp_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl_q[WP_BIT] && wr_addr != A_CTRL)
        |=> ($stable(core_q) && $stable(ram_q) && $stable(trickle_q)));

    // R5: enable bits survive a control write made under protection
    a_r5_ctrl_guarded: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl_q[WP_BIT] && wr_addr == A_CTRL)
        |=> (ctrl_q[2:0] == $past(ctrl_q[2:0])));

    // R5: unused control bits never become set
    a_r5_ctrl_unused: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~CTRL_KEEP) == '0);

endmodule

// File: rtl/spi_rtc_regfile.sv
module spi_rtc_regfile
    import spi_rtc_regfile_pkg::*;
#(
    parameter int RAM_DEPTH   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_ce,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    logic              sck_rise, sck_fall, mosi_s, ce_s;
    logic              byte_done, miso_q;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              load_en, wr_en;

    phase_t            phase_q;
    logic              wr_q;
    logic [ADDR_W-1:0] ptr_q;
    cmd_t              cmd;

    spi_rtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_i    (spi_sck),
        .mosi_i   (spi_mosi),
        .ce_i     (spi_ce),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s),
        .ce_s     (ce_s)
    );

    assign cmd     = decode_cmd(rx_byte);
    assign rd_addr = (phase_q == PH_CMD) ? cmd.addr : ptr_q;
    assign load_en = byte_done && ((phase_q == PH_CMD) ? !cmd.wr : !wr_q);
    assign wr_en   = byte_done && (phase_q == PH_DATA) && wr_q;

    spi_rtc_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .ce_s      (ce_s),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .load_en   (load_en),
        .load_data (rd_data),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso_q    (miso_q)
    );

    // Transaction sequencer: command byte first, then a walking pointer.
    always_ff @(posedge clk) begin
        if (rst || !ce_s) begin
            phase_q <= PH_CMD;
            wr_q    <= 1'b0;
            ptr_q   <= '0;
        end else if (byte_done) begin
            if (phase_q == PH_CMD) begin
                phase_q <= PH_DATA;
                wr_q    <= cmd.wr;
                ptr_q   <= cmd.wr ? cmd.addr : cmd.addr + 1'b1;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    spi_rtc_regbank #(.RAM_DEPTH(RAM_DEPTH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (ptr_q),
        .wr_data  (rx_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    assign spi_miso = ce_s && (phase_q == PH_DATA) && !wr_q && miso_q;

    // R8: nothing leaves on MISO while the command byte is shifting in
    a_r8_quiet_in_cmd: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CMD) |-> !spi_miso);

    // R8: a write transaction keeps MISO low
    a_r8_quiet_in_write: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && wr_q) |-> !spi_miso);

    // R3: each data byte moves the pointer by one, wrapping at the top
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase_q == PH_DATA && ce_s)
        |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R9: a dropped chip enable returns the sequencer to the command phase
    a_r9_fresh_cmd: assert property (@(posedge clk) disable iff (rst)
        !ce_s |=> (phase_q == PH_CMD));

endmodule

// File: tb/tb_spi_rtc_regfile.sv
module tb_spi_rtc_regfile;
    localparam int RAM_DEPTH = 32;
    localparam int HALF      = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       spi_sck, spi_mosi, spi_ce;
    logic       spi_miso;
    logic [6:0] dbg_addr;
    logic [7:0] dbg_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] mdl  [128];
    logic [7:0] wbuf [128];
    logic [7:0] rbuf [128];

    always #10 clk = ~clk;

    spi_rtc_regfile #(.RAM_DEPTH(RAM_DEPTH)) dut (
        .clk      (clk),
        .rst      (rst),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_ce   (spi_ce),
        .spi_miso (spi_miso),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    // Model of a single byte written at address a
    function automatic void mdl_wr(input int a, input logic [7:0] v);
        if (a == 15) begin
            if (mdl[15][6]) mdl[15][6] = v[6];
            else            mdl[15]    = v & 8'h47;
        end else if (!mdl[15][6]) begin
            if (a <= 14 || a == 17 || (a >= 32 && a < 32 + RAM_DEPTH))
                mdl[a] = v;
        end
    endfunction

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        spi_ce = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        spi_ce = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic burst_write(input int a, input int n);
        logic [7:0] rx;
        logic [7:0] acc;
        cs_begin();
        spi_bits(8'h80 | 8'(a), 8, rx);
        acc = rx;
        for (int k = 0; k < n; k++) begin
            spi_bits(wbuf[k], 8, rx);
            acc |= rx;
            mdl_wr((a + k) % 128, wbuf[k]);
        end
        cs_end();
        chk(acc, 8'h00, "R8 miso low during write");
    endtask

    task automatic burst_read(input int a, input int n);
        logic [7:0] rx;
        cs_begin();
        spi_bits(8'(a) & 8'h7F, 8, rx);
        chk(rx, 8'h00, "R8 miso low during command");
        for (int k = 0; k < n; k++) begin
            spi_bits(8'h00, 8, rx);
            rbuf[k] = rx;
        end
        cs_end();
    endtask

    task automatic read_and_check(input int a, input int n, input string tag);
        burst_read(a, n);
        for (int k = 0; k < n; k++) chk(rbuf[k], mdl[(a + k) % 128], tag);
    endtask

    task automatic dbg_sweep(input string tag);
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            dbg_addr = 7'(a);
            @(negedge clk);
            chk(dbg_data, mdl[a], tag);
        end
    endtask

    initial begin
        logic [7:0] rx;
        rst      = 1'b1;
        spi_sck  = 1'b0;
        spi_mosi = 1'b0;
        spi_ce   = 1'b0;
        dbg_addr = '0;
        for (int a = 0; a < 128; a++) mdl[a] = 8'h00;
        mdl[15] = 8'h40;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1, R10: reset contents seen through the debug port
        dbg_sweep("R1 R10 reset contents");

        // R8: MISO idle with chip enable low
        repeat (3) begin
            repeat (5) @(negedge clk);
            chk(8'(spi_miso), 8'h00, "R8 miso low with ce low");
        end

        // R2: serial read of the control register after reset
        read_and_check(15, 1, "R2 read control");

        // R4: protected burst writes are dropped
        for (int k = 0; k < 3; k++) wbuf[k] = 8'h5A + 8'(k);
        burst_write(0, 3);
        read_and_check(0, 3, "R4 protected write ignored");

        // R5: unprotected by a control write of 0x00
        wbuf[0] = 8'h00;
        burst_write(15, 1);
        chk(mdl[15], 8'h00, "R5 model sanity");
        read_and_check(15, 1, "R5 protect cleared");

        // R3, R11, R4: full burst over 0x00-0x11; control gets 0x6C mid-burst
        for (int k = 0; k < 18; k++) wbuf[k] = 8'(k * 7 + 3);
        burst_write(0, 18);
        read_and_check(0, 18, "R3 R11 burst over core registers");
        chk(mdl[15], 8'h44, "R4 protect raised mid-burst model");

        // R5: two-step clear from a protected control register
        wbuf[0] = 8'h00;
        burst_write(15, 1);
        read_and_check(15, 1, "R5 first clear keeps enables");
        chk(mdl[15], 8'h04, "R5 model after first clear");
        burst_write(15, 1);
        read_and_check(15, 1, "R5 second clear");

        // R6, R11: status is read-only, trickle stores
        wbuf[0] = 8'hFF;
        wbuf[1] = 8'hA5;
        burst_write(16, 2);
        read_and_check(16, 2, "R6 R11 status and trickle");

        // R11: RAM full burst
        for (int k = 0; k < RAM_DEPTH; k++) wbuf[k] = 8'hF0 ^ 8'(k * 13);
        burst_write(32, RAM_DEPTH);
        read_and_check(32, RAM_DEPTH, "R11 ram burst");

        // R7: unimplemented gaps
        for (int k = 0; k < 14; k++) wbuf[k] = 8'hC3;
        burst_write(18, 14);
        read_and_check(18, 14, "R7 gap below ram");
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h3C;
        burst_write(32 + RAM_DEPTH, 4);
        read_and_check(32 + RAM_DEPTH, 4, "R7 gap above ram");

        // R3: wrap from 0x7F to 0x00
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h99; wbuf[3] = 8'h66;
        burst_write(126, 4);
        read_and_check(127, 3, "R3 address wrap");

        // R9: a partial byte is discarded when chip enable drops
        cs_begin();
        spi_bits(8'h85, 8, rx);
        spi_bits(8'hFF, 5, rx);
        cs_end();
        read_and_check(5, 1, "R9 partial byte dropped");
        wbuf[0] = 8'h77;
        burst_write(5, 1);
        read_and_check(5, 1, "R9 fresh command after drop");

        // R10: final full agreement
        dbg_sweep("R10 final contents");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule